// File: doc/BRIEF.md
# Merging Cell Reassembly Output Stage

This block sits at one output port of a cell switch. It gathers the cells of each incoming virtual circuit until that circuit's packet is complete. It then hands the whole packet to a single outgoing cell stream, where it carries an outgoing circuit identifier looked up in a merge table. Several incoming circuits may share one outgoing identifier. A receiver downstream can only tell packets apart by their end-of-packet marker, so the cells of two packets must never be interleaved on the output.

Every arriving cell carries an input-port tag, an incoming circuit number, an end-of-packet flag and a payload word. The port tag and the circuit number together select one reassembly queue. All queues, and the output queue, are linked lists threaded through one shared pool of cell slots. A completed packet is spliced onto the output list in a single pointer write, so its cells are never copied.

When the pool is exhausted, or a queue has no valid merge-table entry, the offending cell is dropped. The rest of that packet is then discarded and its slots are reclaimed. The outgoing stream uses a valid/ready handshake, and a slot returns to the pool when its cell is accepted.

Top module: `vcm_reasm_top`

## Requirements
- R1: After reset the output is idle, the drop count reads zero and all POOL_DEPTH slots are free.
- R2: No cell of a packet whose end-of-packet cell has not yet been stored ever appears at the output.
- R3: Once a packet's end-of-packet cell is stored, all of its cells leave back-to-back in arrival order, with only the last one flagged end-of-packet. Completed packets leave in the order in which their end-of-packet cells arrived.
- R4: Every output cell carries the outgoing VCI held in the merge table at index {in_port, in_vci}, which is the queue index. Packets from different queues that map to one outgoing VCI still leave as unbroken packets, even when their cells arrived interleaved.
- R5: A queue accepts the first cell of its next packet in the cycle straight after its end-of-packet cell.
- R6: A cell that arrives while all POOL_DEPTH slots are occupied is dropped, and its queue's partial packet is freed. Every later cell of that queue is dropped up to and including the next end-of-packet cell, and the packet after that is accepted normally.
- R7: A cell whose queue has no valid merge-table entry is dropped, and so is the rest of its packet.
- R8: drop_cnt rises by exactly one for every dropped cell and by nothing otherwise.
- R9: While out_valid is high and out_ready is low, the output cell stays unchanged. A slot is reused once its cell has been accepted.
- R10: A merge-table write applies to packets completed after it. Packets already waiting at the output are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An arriving cell is present |
| in_port | input | PORT_W | Input-port tag of the cell |
| in_vci | input | VCI_W | Incoming circuit number |
| in_eop | input | 1 | Cell ends its packet |
| in_data | input | DATA_W | Payload word |
| tbl_we | input | 1 | Merge-table write strobe |
| tbl_idx | input | PORT_W+VCI_W | Queue index to program |
| tbl_ovci | input | OVCI_W | Outgoing VCI for that queue |
| tbl_valid | input | 1 | Entry usable |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream accepts the cell |
| out_vci | output | OVCI_W | Translated outgoing VCI |
| out_eop | output | 1 | Output cell ends its packet |
| out_data | output | DATA_W | Payload word |
| drop_cnt | output | DROP_W | Count of dropped cells |

## Verification
The bench interleaves the cells of queues that share one outgoing VCI. A design that forwarded cells before the end-of-packet cell, or that spliced lists carelessly, would mix two packets in the reference comparison. It runs the pool to exactly full with the output stalled and then sends one more cell and an end-of-packet cell. A design that dropped one cell too early, failed to reclaim the partial packet, or left discard mode at the wrong point would show a wrong drop count or an unexpected packet. It also starts a new packet on a queue in the very cycle after its end-of-packet cell, while that queue's splice is under way, and rewrites the table between packets. A wrong splice hazard or a stale translation shows up as corrupted order or a wrong VCI.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    localparam int DATA_W = 16;
    localparam int OVCI_W = 8;

    typedef logic [DATA_W-1:0] payload_t;
    typedef logic [OVCI_W-1:0] ovci_t;

    typedef struct packed {
        payload_t data;
        logic     eop;
    } cell_t;

    function automatic cell_t make_cell(payload_t d, logic e);
        cell_t c;
        c.data = d;
        c.eop  = e;
        return c;
    endfunction
endpackage

// File: rtl/vcm_merge_table.sv
module vcm_merge_table
    import vcm_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = 3
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [QW-1:0] w_idx,
    input  ovci_t         w_vci,
    input  logic          w_ok,
    input  logic [QW-1:0] a_idx,
    output logic          a_ok,
    input  logic [QW-1:0] b_idx,
    output ovci_t         b_vci
);
    ovci_t         vci_tab [NQ];
    logic [NQ-1:0] ok_tab;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_tab <= '0;
        end else if (we) begin
            ok_tab[w_idx] <= w_ok;
        end
        if (we) begin
            vci_tab[w_idx] <= w_vci;
        end
    end

    assign a_ok  = ok_tab[a_idx];
    assign b_vci = vci_tab[b_idx];
endmodule

// File: rtl/vcm_pool_alloc.sv
module vcm_pool_alloc #(
    parameter int DEPTH = 16,
    parameter int PW    = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic             free_en,
    input  logic [PW-1:0]    free_ptr,
    input  logic [DEPTH-1:0] free_mask,
    output logic [PW-1:0]    alloc_ptr,
    output logic             full
);
    logic [DEPTH-1:0] used;
    logic [DEPTH-1:0] take;
    logic [DEPTH-1:0] give;

    always_comb begin
        alloc_ptr = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) alloc_ptr = PW'(i);
        end
    end

    assign full = &used;

    always_comb begin
        take = '0;
        give = free_mask;
        if (alloc_en) take[alloc_ptr] = 1'b1;
        if (free_en)  give[free_ptr]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) used <= '0;
        else     used <= (used & ~give) | take;
    end
endmodule

// File: rtl/vcm_cell_store.sv
module vcm_cell_store
    import vcm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 4,
    parameter int QW    = 3
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_ptr,
    input  cell_t            wr_cell,
    input  logic [QW-1:0]    wr_owner,
    input  logic             la_en,
    input  logic [PW-1:0]    la_ptr,
    input  logic [PW-1:0]    la_val,
    input  logic             lb_en,
    input  logic [PW-1:0]    lb_ptr,
    input  logic [PW-1:0]    lb_val,
    input  logic             sp_en,
    input  logic [QW-1:0]    sp_q,
    input  ovci_t            sp_vci,
    input  logic             dc_en,
    input  logic [QW-1:0]    dc_q,
    output logic [DEPTH-1:0] dc_mask,
    input  logic [PW-1:0]    rd_ptr,
    output cell_t            rd_cell,
    output ovci_t            rd_vci,
    output logic [PW-1:0]    rd_next
);
    cell_t            cells [DEPTH];
    ovci_t            vcis  [DEPTH];
    logic [PW-1:0]    nxt   [DEPTH];
    logic [QW-1:0]    owner [DEPTH];
    logic [DEPTH-1:0] in_rq;
    logic [DEPTH-1:0] sp_mask;

    always_comb begin
        for (int c = 0; c < DEPTH; c++) begin
            sp_mask[c] = sp_en && in_rq[c] && (owner[c] == sp_q);
            dc_mask[c] = dc_en && in_rq[c] && (owner[c] == dc_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_rq <= '0;
        end else begin
            for (int c = 0; c < DEPTH; c++) begin
                if (wr_en && wr_ptr == PW'(c))      in_rq[c] <= 1'b1;
                else if (sp_mask[c] || dc_mask[c]) in_rq[c] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < DEPTH; c++) begin
            if (wr_en && wr_ptr == PW'(c)) begin
                cells[c] <= wr_cell;
                owner[c] <= wr_owner;
            end
            if (sp_mask[c]) vcis[c] <= sp_vci;
            if (la_en && la_ptr == PW'(c))      nxt[c] <= la_val;
            else if (lb_en && lb_ptr == PW'(c)) nxt[c] <= lb_val;
        end
    end

    assign rd_cell = cells[rd_ptr];
    assign rd_vci  = vcis[rd_ptr];
    assign rd_next = nxt[rd_ptr];
endmodule

// File: rtl/vcm_reasm_top.sv
module vcm_reasm_top
    import vcm_pkg::*;
#(
    parameter int PORT_W     = 1,
    parameter int VCI_W      = 2,
    parameter int POOL_DEPTH = 16,
    parameter int DROP_W     = 16
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PORT_W-1:0]       in_port,
    input  logic [VCI_W-1:0]        in_vci,
    input  logic                    in_eop,
    input  logic [DATA_W-1:0]       in_data,
    input  logic                    tbl_we,
    input  logic [PORT_W+VCI_W-1:0] tbl_idx,
    input  logic [OVCI_W-1:0]       tbl_ovci,
    input  logic                    tbl_valid,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [OVCI_W-1:0]       out_vci,
    output logic                    out_eop,
    output logic [DATA_W-1:0]       out_data,
    output logic [DROP_W-1:0]       drop_cnt
);
    localparam int QW = PORT_W + VCI_W;
    localparam int NQ = 1 << QW;
    localparam int PW = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1;
    localparam int CW = $clog2(POOL_DEPTH + 1);

    logic [PW-1:0]     q_head [NQ];
    logic [PW-1:0]     q_tail [NQ];
    logic [CW-1:0]     q_cnt  [NQ];
    logic [NQ-1:0]     q_done, q_skip;
    logic [PW-1:0]     o_head, o_tail;
    logic [CW-1:0]     o_cnt;
    logic [DROP_W-1:0] drops;

    logic              sp_en;
    logic [QW-1:0]     sp_q, arr_q;
    ovci_t             sp_vci;
    logic              map_ok_arr, pool_full, bad;
    logic              view_empty, arr_drop, arr_store, dc_en, pop;
    logic [PW-1:0]     alloc_ptr, rd_next;
    logic [POOL_DEPTH-1:0] dc_mask;
    cell_t             rd_cell;
    ovci_t             rd_vci;

    // fixed-priority pick of a completed queue: lowest index first
    always_comb begin
        sp_en = 1'b0;
        sp_q  = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (q_done[i]) begin
                sp_en = 1'b1;
                sp_q  = QW'(i);
            end
        end
    end

    assign arr_q      = {in_port, in_vci};
    assign bad        = !map_ok_arr || pool_full;
    assign arr_drop   = in_valid && (q_skip[arr_q] || bad);
    assign arr_store  = in_valid && !arr_drop;
    assign view_empty = (sp_en && sp_q == arr_q) || (q_cnt[arr_q] == '0);
    assign dc_en      = in_valid && !q_skip[arr_q] && bad && !(sp_en && sp_q == arr_q);
    assign out_valid  = (o_cnt != '0);
    assign pop        = out_valid && out_ready;

    vcm_merge_table #(.NQ(NQ), .QW(QW)) u_tab (
        .clk(clk), .rst(rst),
        .we(tbl_we), .w_idx(tbl_idx), .w_vci(tbl_ovci), .w_ok(tbl_valid),
        .a_idx(arr_q), .a_ok(map_ok_arr),
        .b_idx(sp_q), .b_vci(sp_vci)
    );

    vcm_pool_alloc #(.DEPTH(POOL_DEPTH), .PW(PW)) u_alloc (
        .clk(clk), .rst(rst),
        .alloc_en(arr_store), .free_en(pop), .free_ptr(o_head),
        .free_mask(dc_mask), .alloc_ptr(alloc_ptr), .full(pool_full)
    );

    vcm_cell_store #(.DEPTH(POOL_DEPTH), .PW(PW), .QW(QW)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(arr_store), .wr_ptr(alloc_ptr),
        .wr_cell(make_cell(in_data, in_eop)), .wr_owner(arr_q),
        .la_en(arr_store && !view_empty), .la_ptr(q_tail[arr_q]), .la_val(alloc_ptr),
        .lb_en(sp_en && o_cnt != '0), .lb_ptr(o_tail), .lb_val(q_head[sp_q]),
        .sp_en(sp_en), .sp_q(sp_q), .sp_vci(sp_vci),
        .dc_en(dc_en), .dc_q(arr_q), .dc_mask(dc_mask),
        .rd_ptr(o_head), .rd_cell(rd_cell), .rd_vci(rd_vci), .rd_next(rd_next)
    );

    // reassembly queue bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NQ; i++) begin
                q_head[i] <= '0;
                q_tail[i] <= '0;
                q_cnt[i]  <= '0;
            end
            q_done <= '0;
            q_skip <= '0;
        end else begin
            if (sp_en) begin
                q_cnt[sp_q]  <= '0;
                q_done[sp_q] <= 1'b0;
            end
            if (dc_en) q_cnt[arr_q] <= '0;
            if (arr_store) begin
                q_tail[arr_q] <= alloc_ptr;
                if (view_empty) begin
                    q_head[arr_q] <= alloc_ptr;
                    q_cnt[arr_q]  <= CW'(1);
                end else begin
                    q_cnt[arr_q]  <= q_cnt[arr_q] + CW'(1);
                end
                if (in_eop) q_done[arr_q] <= 1'b1;
            end
            if (in_valid && !q_skip[arr_q] && bad && !in_eop) q_skip[arr_q] <= 1'b1;
            if (in_valid && q_skip[arr_q] && in_eop)          q_skip[arr_q] <= 1'b0;
        end
    end

    // output list: splice completed packet at tail, pop at head
    always_ff @(posedge clk) begin
        if (rst) begin
            o_head <= '0;
            o_tail <= '0;
            o_cnt  <= '0;
            drops  <= '0;
        end else begin
            if (sp_en) begin
                o_tail <= q_tail[sp_q];
                if (o_cnt == '0 || (pop && o_cnt == CW'(1))) o_head <= q_head[sp_q];
                else if (pop)                                o_head <= rd_next;
            end else if (pop) begin
                o_head <= rd_next;
            end
            o_cnt <= o_cnt - CW'(pop) + (sp_en ? q_cnt[sp_q] : '0);
            if (arr_drop) drops <= drops + DROP_W'(1);
        end
    end

    assign out_data = rd_cell.data;
    assign out_eop  = rd_cell.eop;
    assign out_vci  = rd_vci;
    assign drop_cnt = drops;
endmodule

// File: rtl/vcm_reasm_chk.sv
module vcm_reasm_chk #(
    parameter int NQ     = 8,
    parameter int CW     = 5,
    parameter int DROP_W = 16,
    parameter int DATA_W = 16,
    parameter int OVCI_W = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              map_ok,
    input logic              pool_full,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [OVCI_W-1:0] out_vci,
    input logic [DROP_W-1:0] drop_cnt,
    input logic [CW-1:0]     out_cnt,
    input logic [NQ-1:0]     q_done
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_vci) && $stable(out_eop)); // R9

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> drop_cnt == $past(drop_cnt)); // R8

    AST_LAST_IS_EOP: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cnt == CW'(1) |-> out_eop); // R3

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_done)); // R5

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        in_valid && pool_full |=> drop_cnt == $past(drop_cnt) + DROP_W'(1)); // R6

    AST_UNMAPPED_DROPS: assert property (@(posedge clk) disable iff (rst)
        in_valid && !map_ok |=> drop_cnt == $past(drop_cnt) + DROP_W'(1)); // R7
endmodule

bind vcm_reasm_top vcm_reasm_chk #(
    .NQ(NQ), .CW(CW), .DROP_W(DROP_W), .DATA_W(vcm_pkg::DATA_W), .OVCI_W(vcm_pkg::OVCI_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .map_ok(map_ok_arr), .pool_full(pool_full),
    .out_valid(out_valid), .out_ready(out_ready), .out_eop(out_eop), .out_data(out_data),
    .out_vci(out_vci), .drop_cnt(drop_cnt), .out_cnt(o_cnt), .q_done(q_done)
);

// File: tb/tb_vcm_reasm_top.sv
`timescale 1ns/1ps
module tb_vcm_reasm_top;
    import vcm_pkg::*;
    localparam int PORT_W = 1;
    localparam int VCI_W  = 2;
    localparam int POOL   = 16;
    localparam int DROP_W = 16;
    localparam int NQ     = 1 << (PORT_W + VCI_W);

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic              e;
        logic [OVCI_W-1:0] v;
    } rec_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_eop = 1'b0, tbl_we = 1'b0, tbl_valid = 1'b0, out_ready = 1'b0;
    logic [PORT_W-1:0] in_port = '0;
    logic [VCI_W-1:0] in_vci = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [PORT_W+VCI_W-1:0] tbl_idx = '0;
    logic [OVCI_W-1:0] tbl_ovci = '0;
    logic out_valid, out_eop;
    logic [OVCI_W-1:0] out_vci;
    logic [DATA_W-1:0] out_data;
    logic [DROP_W-1:0] drop_cnt;

    vcm_reasm_top #(.PORT_W(PORT_W), .VCI_W(VCI_W), .POOL_DEPTH(POOL), .DROP_W(DROP_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port), .in_vci(in_vci),
        .in_eop(in_eop), .in_data(in_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_ovci(tbl_ovci), .tbl_valid(tbl_valid), .out_valid(out_valid),
        .out_ready(out_ready), .out_vci(out_vci), .out_eop(out_eop), .out_data(out_data),
        .drop_cnt(drop_cnt)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int rdy_pct = 100;
    int m_occ = 0, m_drops = 0;
    bit m_ok [NQ];
    bit m_skip [NQ];
    logic [OVCI_W-1:0] m_vci [NQ];
    logic [DATA_W-1:0] pd [NQ][POOL];
    int pn [NQ];
    rec_t exp_q [$];
    logic [DATA_W-1:0] seq = 16'h0100;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic model_arrive(int q, bit e, logic [DATA_W-1:0] d);
        bit bad = !m_ok[q] || (m_occ == POOL);
        if (m_skip[q]) begin
            m_drops++;
            if (e) m_skip[q] = 0;
        end else if (bad) begin
            m_drops++;
            m_occ -= pn[q];
            pn[q] = 0;
            if (!e) m_skip[q] = 1;
        end else begin
            pd[q][pn[q]] = d;
            pn[q]++;
            m_occ++;
            if (e) begin
                for (int k = 0; k < pn[q]; k++) exp_q.push_back({pd[q][k], (k == pn[q] - 1), m_vci[q]});
                pn[q] = 0;
            end
        end
    endtask

    task automatic step(bit v, int q, bit e);
        rec_t r;
        @(negedge clk);
        tbl_we    = 1'b0;
        out_ready = ($urandom_range(99) < rdy_pct);
        in_valid  = v;
        in_port   = PORT_W'(q >> VCI_W);
        in_vci    = VCI_W'(q);
        in_eop    = e;
        seq       = seq + 16'd1;
        in_data   = seq;
        if (v) model_arrive(q, e, seq);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2", "cell with no completed packet", longint'(out_data), 0);
            end else begin
                r = exp_q.pop_front();
                chk(out_data == r.d && out_eop == r.e, "R3", "data/eop order",
                    longint'({out_data, out_eop}), longint'({r.d, r.e}));
                chk(out_vci == r.v, "R4", "translated vci", longint'(out_vci), longint'(r.v));
                m_occ--;
            end
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0);
    endtask

    task automatic tbl(int q, logic [OVCI_W-1:0] v, bit ok);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        tbl_we    = 1'b1;
        tbl_idx   = (PORT_W + VCI_W)'(q);
        tbl_ovci  = v;
        tbl_valid = ok;
        m_vci[q]  = v;
        m_ok[q]   = ok;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        logic [DATA_W-1:0] hold_d;
        logic [OVCI_W-1:0] hold_v;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NQ; i++) begin
            m_ok[i] = 0; m_skip[i] = 0; pn[i] = 0; m_vci[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(drop_cnt == '0, "R1", "drop_cnt after reset", drop_cnt, 0);

        tbl(0, 8'h10, 1); tbl(1, 8'h42, 1); tbl(2, 8'h42, 1); tbl(3, 8'h30, 1);
        tbl(4, 8'h42, 1); tbl(5, 8'h55, 0); tbl(6, 8'h60, 1); tbl(7, 8'h60, 1);

        // R2: partial packet must not leak
        rdy_pct = 100;
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        idle(4);
        chk(out_valid == 1'b0, "R2", "partial packet visible", out_valid, 0);
        step(1, 0, 1);
        idle(6);

        // R4: interleaved arrivals merged onto one outgoing vci
        step(1, 1, 0); step(1, 2, 0); step(1, 1, 0); step(1, 2, 0);
        step(1, 1, 1); step(1, 2, 1);
        idle(10);

        // R5: next packet starts right after eop on the same queue
        step(1, 4, 1); step(1, 4, 0); step(1, 4, 1); step(1, 6, 1); step(1, 4, 1);
        idle(8);

        // R7: unmapped queue drops the whole packet
        base = drop_cnt;
        step(1, 5, 0); step(1, 5, 0); step(1, 5, 1);
        idle(3);
        chk(int'(drop_cnt) == base + 3, "R7", "unmapped drops", drop_cnt, base + 3);
        idle(6);
        chk(exp_q.size() == 0, "R3", "output drained", exp_q.size(), 0);

        // R6: pool exhaustion with the output stalled
        rdy_pct = 0;
        base = drop_cnt;
        for (int k = 0; k < POOL; k++) step(1, 3, 0);
        idle(1);
        chk(int'(drop_cnt) == base, "R1", "full pool stored without drops", drop_cnt, base);
        step(1, 3, 0);
        idle(1);
        chk(int'(drop_cnt) == base + 1, "R6", "drop on full pool", drop_cnt, base + 1);
        step(1, 3, 1);
        idle(1);
        chk(int'(drop_cnt) == base + 2, "R6", "discard through eop", drop_cnt, base + 2);
        chk(out_valid == 1'b0, "R6", "discarded packet absent", out_valid, 0);
        step(1, 3, 0); step(1, 3, 1); step(1, 7, 0); step(1, 7, 1);
        idle(3);
        chk(out_valid == 1'b1, "R6", "packet after discard", out_valid, 1);
        // R9: stalled output holds its cell
        hold_d = out_data; hold_v = out_vci;
        idle(2);
        chk(out_data == hold_d && out_vci == hold_v, "R9", "stall hold",
            longint'({out_data, out_vci}), longint'({hold_d, hold_v}));
        rdy_pct = 100;
        idle(8);
        chk(int'(drop_cnt) == base + 2, "R6", "no extra drops", drop_cnt, base + 2);

        // R10: table rewrite applies to later packets
        tbl(0, 8'h77, 1);
        step(1, 0, 0); step(1, 0, 1);
        idle(6);

        // R9: slot reuse after acceptance, random traffic
        rdy_pct = 70;
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(99) < 60, int'($urandom_range(NQ - 1)), $urandom_range(2) == 0);
        end
        rdy_pct = 100;
        idle(3 * POOL);
        chk(exp_q.size() == 0, "R3", "all completed packets delivered", exp_q.size(), 0);
        chk(int'(drop_cnt) == m_drops, "R8", "total drop count", drop_cnt, m_drops);
        finish_run();
    end
endmodule